// File: doc/BRIEF.md
# SPI Master Channel Engine

This block is a single channel of a multichannel SPI master. It holds a 23-bit channel configuration, a three-flag status, an enable bit, and the transmit and receive data words. Software or a DMA engine writes a word to the transmit register. The block then decides whether an exchange may start. If it may, it clocks the word out MSB first in SPI mode 0, captures the word returned on the input line, and updates the status flags.

Start decisions are gated by several things: the receive-full and transmit-empty flags, a three-way transfer mode (full duplex, receive only, transmit only) and a turbo bit. A turbo channel may shift a new word while the previous received word is still unread. The same gating drives two DMA request levels and two one-cycle event pulses (transmit empty, receive full) meant for an interrupt collector outside the block. When the module runs in single-channel mode, a word reaches the wire only if the channel's force bit is set. Without force, the status sequence still completes as if a word had been sent.

Top module: `spi_chan_engine`

## Requirements
- R1: After reset the status reads 3'b010 (bit 2 end-of-transfer, bit 1 transmit-empty, bit 0 receive-full), the configuration reads 23'h060000, the channel is disabled, chip select is high and both DMA requests are low.
- R2: The word length is configuration bits 11:7 plus one. A word is shifted MSB first in mode 0 with a serial clock of one quarter of the system clock: output changes while the clock is low and input is sampled on the rising edge. Exactly that many clock pulses occur while chip select is low, and the received word is right-aligned with zero upper bits.
- R3: A transmit-register write stores the word, clears transmit-empty on the next cycle and requests a transfer attempt.
- R4: An attempt is dropped while the enable bit is clear. A control write that takes enable from 0 to 1 requests a new attempt.
- R5: A set receive-full flag blocks a transfer, unless the mode (configuration bits 13:12) is 2, transmit only, or configuration bit 19 (turbo) is set.
- R6: A set transmit-empty flag blocks a transfer, unless the mode is 1, receive only.
- R7: While the single-channel input is high and configuration bit 20 (force) is clear, no word is shifted. The completion still happens, and the receive register keeps its previous value.
- R8: On completion the transmit register clears and end-of-transfer and transmit-empty are set. Receive-full is also set unless the mode is transmit only.
- R9: A receive-register read clears receive-full on the next cycle and requests a transfer attempt. In receive-only mode this starts the next word.
- R10: The write DMA request is high when the channel is enabled, configuration bit 14 is set, transmit-empty is set and the mode is not receive only. The read DMA request is high when the channel is enabled, configuration bit 15 is set, receive-full is set and the mode is not transmit only.
- R11: After each blocked attempt or completion, a one-cycle transmit-empty event fires if transmit-empty is set and the mode is not receive only. A one-cycle receive-full event fires if receive-full is set, the mode is not transmit only and turbo is off.
- R12: The configuration-error output is high when the length field is below 3 or the mode field is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write configuration from wr_data[22:0] |
| ctl_we | input | 1 | Write enable bit from wr_data[0] |
| tx_we | input | 1 | Write transmit register from wr_data |
| rx_re | input | 1 | Receive-register read strobe |
| wr_data | input | 32 | Write data |
| single_mode | input | 1 | Module is in single-channel mode |
| cfg_q | output | 23 | Configuration register |
| stat_q | output | 3 | Status {end-of-transfer, transmit-empty, receive-full} |
| en_q | output | 1 | Channel enable |
| tx_q | output | 32 | Transmit register |
| rx_q | output | 32 | Receive register |
| busy | output | 1 | Word shifting |
| dma_wr_req | output | 1 | DMA request to refill transmit |
| dma_rd_req | output | 1 | DMA request to drain receive |
| ev_tx_empty | output | 1 | Transmit-empty event pulse |
| ev_rx_full | output | 1 | Receive-full event pulse |
| cfg_err | output | 1 | Invalid length or mode programmed |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |

## Verification
Two strobes can arrive together: a receive-register read that clears receive-full and a transmit write that clears transmit-empty, in the same clock. The bench provokes this by leaving a received word unread and then issuing both strobes in one cycle. It passes only if exactly one chip-select assertion follows, the new word from the serial slave model lands in the receive register, and the status returns to 3'b111. A slave model in the bench counts clock pulses, captures the outgoing bits and returns a known word for every length from 4 to 32.

// File: rtl/spi_chan_engine.sv
`timescale 1ns/1ps
module spi_chan_engine #(
  parameter int DW  = 32,
  parameter int DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          ctl_we,
  input  logic          tx_we,
  input  logic          rx_re,
  input  logic [DW-1:0] wr_data,
  input  logic          single_mode,
  output logic [22:0]   cfg_q,
  output logic [2:0]    stat_q,
  output logic          en_q,
  output logic [DW-1:0] tx_q,
  output logic [DW-1:0] rx_q,
  output logic          busy,
  output logic          dma_wr_req,
  output logic          dma_rd_req,
  output logic          ev_tx_empty,
  output logic          ev_rx_full,
  output logic          cfg_err,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso,
  output logic          cs_n
);
  localparam int PW   = $clog2(DIV);
  localparam int HALF = DIV / 2;
  localparam int BW   = $clog2(DW) + 1;

  logic [DW-1:0] sh, rsh;
  logic [PW-1:0] ph;
  logic [BW-1:0] bits;
  logic          pend, evt;

  wire [1:0]    trm     = cfg_q[13:12];
  wire          turbo   = cfg_q[19];
  wire          force_b = cfg_q[20];
  wire [BW-1:0] wl      = BW'(cfg_q[11:7]) + BW'(1);
  wire          rx_hold = stat_q[0] && trm != 2'd2 && !turbo;
  wire          tx_hold = stat_q[1] && trm != 2'd1;
  wire          go      = pend && !busy;
  wire          ph_last = ph == PW'(DIV - 1);

  assign sclk        = busy && ph >= PW'(HALF);
  assign mosi        = !cs_n && sh[DW-1];
  assign ev_tx_empty = evt && tx_hold;
  assign ev_rx_full  = evt && rx_hold;
  assign dma_wr_req  = en_q && cfg_q[14] && stat_q[1] && trm != 2'd1;
  assign dma_rd_req  = en_q && cfg_q[15] && stat_q[0] && trm != 2'd2;
  assign cfg_err     = cfg_q[11:7] < 5'd3 || trm == 2'd3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= 23'h060000;
      stat_q <= 3'b010;
      en_q   <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      busy   <= 1'b0;
      cs_n   <= 1'b1;
      sh     <= '0;
      rsh    <= '0;
      ph     <= '0;
      bits   <= '0;
      pend   <= 1'b0;
      evt    <= 1'b0;
    end else begin
      evt <= 1'b0;
      if (cfg_we) cfg_q <= wr_data[22:0];
      if (ctl_we) en_q <= wr_data[0];

      if (go) begin
        pend <= 1'b0;
        if (en_q) begin
          if (rx_hold || tx_hold) begin
            evt <= 1'b1;
          end else if (!single_mode || force_b) begin
            busy <= 1'b1;
            cs_n <= 1'b0;
            ph   <= '0;
            bits <= wl;
            sh   <= tx_q << (DW - int'(wl));
            rsh  <= '0;
          end else begin
            tx_q      <= '0;
            stat_q[2] <= 1'b1;
            stat_q[1] <= 1'b1;
            if (trm != 2'd2) stat_q[0] <= 1'b1;
            evt <= 1'b1;
          end
        end
      end

      if (busy) begin
        ph <= ph_last ? '0 : ph + PW'(1);
        if (ph == PW'(HALF - 1)) rsh <= {rsh[DW-2:0], miso};
        if (ph_last) begin
          sh   <= sh << 1;
          bits <= bits - BW'(1);
          if (bits == BW'(1)) begin
            busy      <= 1'b0;
            cs_n      <= 1'b1;
            rx_q      <= rsh;
            tx_q      <= '0;
            stat_q[2] <= 1'b1;
            stat_q[1] <= 1'b1;
            if (trm != 2'd2) stat_q[0] <= 1'b1;
            evt <= 1'b1;
          end
        end
      end

      if (tx_we) begin
        tx_q      <= wr_data;
        stat_q[1] <= 1'b0;
        pend      <= 1'b1;
      end
      if (rx_re) begin
        stat_q[0] <= 1'b0;
        pend      <= 1'b1;
      end
      if (ctl_we && wr_data[0] && !en_q) pend <= 1'b1;
    end
  end
endmodule

module spi_chan_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_we,
  input logic        rx_re,
  input logic        single_mode,
  input logic [22:0] cfg_q,
  input logic [2:0]  stat_q,
  input logic        en_q,
  input logic        cs_n,
  input logic        sclk
);
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk); // R2
  AST_TXWR_CLEARS_TXS: assert property (@(posedge clk) disable iff (!rst_n) tx_we |=> !stat_q[1]); // R3
  AST_RXRD_CLEARS_RXS: assert property (@(posedge clk) disable iff (!rst_n) rx_re |=> !stat_q[0]); // R9
  AST_SHIFT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n) |-> $past(en_q)); // R4
  AST_SINGLE_NEEDS_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(!single_mode || cfg_q[20])); // R7
  AST_TXONLY_NO_RXS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[0]) |-> $past(cfg_q[13:12]) != 2'd2); // R8
endmodule

bind spi_chan_engine spi_chan_engine_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tx_we(tx_we), .rx_re(rx_re), .single_mode(single_mode),
  .cfg_q(cfg_q), .stat_q(stat_q), .en_q(en_q), .cs_n(cs_n), .sclk(sclk)
);

// File: tb/spi_chan_engine_tb_top.sv
`timescale 1ns/1ps
module spi_chan_engine_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, ctl_we = 0, tx_we = 0, rx_re = 0, single_mode = 0;
  logic [31:0] wr_data = '0;
  logic [22:0] cfg_q;
  logic [2:0]  stat_q;
  logic en_q, busy, dma_wr_req, dma_rd_req, ev_tx_empty, ev_rx_full, cfg_err;
  logic sclk, mosi, miso, cs_n;
  logic [31:0] tx_q, rx_q;

  always #5 clk = ~clk;

  spi_chan_engine dut_i (.*);

  int checks = 0, fails = 0, falls = 0, nb = 0, n_txe = 0, n_rxf = 0;
  int sl_wl = 8;
  logic [31:0] sl_word = '0, sl_sh = '0, cap = '0;
  bit done = 0;

  assign miso = sl_sh[31];
  always @(negedge cs_n) begin falls++; nb = 0; cap = '0; sl_sh = sl_word << (32 - sl_wl); end
  always @(posedge sclk) begin cap = {cap[30:0], mosi}; nb++; end
  always @(negedge sclk) sl_sh = sl_sh << 1;
  always @(negedge clk) begin
    if (ev_tx_empty) n_txe++;
    if (ev_rx_full) n_rxf++;
  end

  function automatic logic [31:0] mask(int w);
    return (w >= 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input bit c, input bit k, input bit t, input bit r, input logic [31:0] d);
    @(negedge clk);
    cfg_we = c; ctl_we = k; tx_we = t; rx_re = r; wr_data = d;
    @(negedge clk);
    cfg_we = 0; ctl_we = 0; tx_we = 0; rx_re = 0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int f0, t0, r0;
    logic [31:0] prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(stat_q == 3'b010, "R1 status", stat_q, 3'b010);
    chk(cfg_q == 23'h060000, "R1 config", cfg_q, 23'h060000);
    chk(cs_n && !en_q, "R1 cs/en", {cs_n, en_q}, 2'b10);
    chk(!dma_wr_req && !dma_rd_req, "R1 dma", {dma_wr_req, dma_rd_req}, 0);

    pulse(0, 1, 0, 0, 32'h1); settle();
    chk(n_txe == 1 && n_rxf == 0, "R11 enable-rise event", {n_txe, n_rxf}, {32'd1, 32'd0});

    for (int f = 3; f <= 31; f++) begin
      logic [31:0] tw;
      tw = 32'hA5C3_96E1 ^ (f * 32'h0101_0101);
      sl_wl = f + 1; sl_word = ~tw ^ f;
      pulse(1, 0, 0, 0, f << 7);
      t0 = n_txe; r0 = n_rxf;
      pulse(0, 0, 1, 0, tw); settle();
      chk(rx_q == (sl_word & mask(sl_wl)), "R2 rx word", rx_q, sl_word & mask(sl_wl));
      chk(cap == (tw & mask(sl_wl)), "R2 mosi bits", cap, tw & mask(sl_wl));
      chk(nb == sl_wl, "R2 pulse count", nb, sl_wl);
      chk(stat_q == 3'b111 && tx_q == 0, "R8 completion", {stat_q, tx_q}, {3'b111, 32'd0});
      chk(n_txe == t0 + 1 && n_rxf == r0 + 1, "R11 completion events", {n_txe, n_rxf}, {t0 + 1, r0 + 1});
      pulse(0, 0, 0, 1, 0); settle();
      chk(stat_q == 3'b110, "R9 read clears", stat_q, 3'b110);
    end

    sl_wl = 8; sl_word = 32'h3C;
    pulse(1, 0, 0, 0, 7 << 7);
    pulse(0, 0, 1, 0, 32'h5A); settle();
    chk(stat_q == 3'b111, "R8 rxs left set", stat_q, 3'b111);
    f0 = falls; sl_word = 32'hC6;
    @(negedge clk); tx_we = 1; rx_re = 1; wr_data = 32'h81;
    @(negedge clk); tx_we = 0; rx_re = 0;
    settle();
    chk(falls == f0 + 1, "R3 same-cycle read+write one word", falls, f0 + 1);
    chk(rx_q == 32'hC6 && cap == 32'h81, "R2 same-cycle data", {rx_q, cap}, {32'hC6, 32'h81});
    chk(stat_q == 3'b111, "R8 same-cycle status", stat_q, 3'b111);

    f0 = falls;
    pulse(0, 0, 1, 0, 32'h77); settle();
    chk(falls == f0, "R5 rxs blocks", falls, f0);
    chk(stat_q == 3'b101 && tx_q == 32'h77, "R3 tx stored", {stat_q, tx_q}, {3'b101, 32'h77});
    pulse(1, 0, 0, 0, (1 << 19) | (7 << 7));
    r0 = n_rxf;
    pulse(0, 1, 0, 0, 0); pulse(0, 1, 0, 0, 1); settle();
    chk(falls == f0 + 1, "R5 turbo overrides, R4 enable rise", falls, f0 + 1);
    chk(n_rxf == r0, "R11 turbo suppresses rx event", n_rxf, r0);
    chk(cap == 32'h77, "R2 turbo word", cap, 32'h77);

    pulse(0, 0, 0, 1, 0); settle();
    chk(falls == f0 + 1 && stat_q == 3'b110, "R6 txs blocks", {falls, stat_q}, {f0 + 1, 3'b110});

    sl_word = 32'h9B; f0 = falls;
    pulse(1, 0, 0, 0, (1 << 12) | (3 << 14) | (7 << 7));
    chk(falls == f0, "R6 cfg write no attempt", falls, f0);
    pulse(0, 0, 0, 1, 0); settle();
    chk(falls == f0 + 1 && stat_q == 3'b111, "R6 rx-only runs", {falls, stat_q}, {f0 + 1, 3'b111});
    chk(rx_q == 32'h9B, "R6 rx-only data", rx_q, 32'h9B);
    chk(dma_rd_req && !dma_wr_req, "R10 rx-only dma", {dma_rd_req, dma_wr_req}, 2'b10);
    pulse(0, 0, 0, 1, 0); settle();
    chk(falls == f0 + 2, "R9 read starts next", falls, f0 + 2);

    pulse(1, 0, 0, 0, (2 << 12) | (3 << 14) | (7 << 7));
    pulse(0, 0, 0, 1, 0); settle();
    chk(stat_q == 3'b110, "R6 tx-only held by txs", stat_q, 3'b110);
    chk(dma_wr_req && !dma_rd_req, "R10 tx-only dma", {dma_wr_req, dma_rd_req}, 2'b10);
    f0 = falls;
    pulse(0, 0, 1, 0, 32'h12); settle();
    chk(falls == f0 + 1 && stat_q == 3'b110, "R8 tx-only no rxs", {falls, stat_q}, {f0 + 1, 3'b110});
    pulse(1, 0, 0, 0, (2 << 12) | (7 << 7));
    chk(!dma_wr_req, "R10 dma bit off", dma_wr_req, 0);
    pulse(0, 1, 0, 0, 0);
    chk(!dma_wr_req, "R10 disabled dma", dma_wr_req, 0);
    pulse(0, 1, 0, 0, 1); settle();

    pulse(1, 0, 0, 0, 7 << 7);
    single_mode = 1; prev = rx_q; f0 = falls;
    pulse(0, 0, 1, 0, 32'h44); settle();
    chk(falls == f0, "R7 no shift without force", falls, f0);
    chk(stat_q == 3'b111 && tx_q == 0, "R7 status completes", {stat_q, tx_q}, {3'b111, 32'd0});
    chk(rx_q == prev, "R7 rx unchanged", rx_q, prev);
    pulse(1, 0, 0, 0, (1 << 20) | (7 << 7));
    pulse(0, 0, 0, 1, 0); settle();
    pulse(0, 0, 1, 0, 32'hE7); settle();
    chk(falls == f0 + 1 && cap == 32'hE7, "R7 force shifts", {falls, cap}, {f0 + 1, 32'hE7});
    single_mode = 0;

    pulse(0, 0, 0, 1, 0); settle();
    pulse(0, 1, 0, 0, 0); f0 = falls;
    pulse(0, 0, 1, 0, 32'h3); settle();
    chk(falls == f0 && !stat_q[1], "R4 disabled no shift", {falls, stat_q}, {f0, 3'b100});
    pulse(0, 1, 0, 0, 1); settle();
    chk(falls == f0 + 1 && stat_q == 3'b111, "R4 enable rise runs", {falls, stat_q}, {f0 + 1, 3'b111});

    pulse(1, 0, 0, 0, 2 << 7);
    chk(cfg_err, "R12 short length", cfg_err, 1);
    pulse(1, 0, 0, 0, (3 << 12) | (7 << 7));
    chk(cfg_err, "R12 mode 3", cfg_err, 1);
    pulse(1, 0, 0, 0, 3 << 7);
    chk(!cfg_err, "R12 valid", cfg_err, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule